// File: doc/BRIEF.md
# ADC Channel-List Sequencer With FIFO

This block controls a 16-input multiplexed 12-bit converter through a small 16-bit register port. Software loads a list of conversion entries. Each entry is one byte that names an input channel, a gain code, a polarity and a single-ended or differential hookup. Conversions are started in one of three ways: a read of the start register, a scan tick input, or an edge on the external trigger pin.

For each conversion, the selection from the current list entry is driven to the analog front end and a one-cycle start pulse goes to the converter. The block then waits for the converter's done handshake and stores the 12-bit result in a result FIFO. Software pops results by reading the data register. A status register reports FIFO levels and five sticky interrupt-pending flags. The interrupt line combines those flags under a per-source mask and a global enable.

Top module: `adc_list_seq`

## Requirements
- R1: After reset, status reads 0x0004 (only the result-empty flag, bit 2, set), the interrupt output is low and no conversion start is issued.
- R2: Control word 1 (write, offset 0x0) bits [1:0] pick the trigger source: 0 off, 1 read of offset 0x0, 2 `scan_tick`, 3 external edge. In mode 0, no source starts a conversion. Each accepted trigger gives exactly one single-cycle `conv_start`, and a trigger that arrives while a conversion is still open is ignored.
- R3: A list entry written at offset 0x10 carries the channel in bits [3:0], the gain in [5:4], unipolar in bit 6 and differential in bit 7. These fields appear on `fe_chan`, `fe_gain`, `fe_unipolar` and `fe_diff` for the conversion that uses the entry.
- R4: A read of offset 0x10 returns the oldest result in bits [11:0] (upper bits zero) and removes it, so results come back in conversion order.
- R5: A read of offset 0x10 while the result FIFO is empty returns the last value removed and changes nothing.
- R6: Both FIFOs hold 16 entries. A list write or a result push into a full FIFO is dropped.
- R7: Control word 2 (offset 0x2) bit 10 enables the result FIFO and bit 9 enables the list. While either bit is clear, that FIFO is kept empty and writes or pushes to it are lost.
- R8: Status (read, offset 0x4) has result full in bit 4, result at least half full in bit 3, result empty in bit 2, list full in bit 1 and conversion busy in bit 0.
- R9: With control word 1 bit 2 clear, entries are used in order once. A trigger after the last entry is ignored, and completing the last entry sets the list-done pending flag (status bit 10).
- R10: With control word 1 bit 2 set, the list pointer returns to the first entry after the last one, and conversions continue.
- R11: Control word 1 bit 3 selects the falling edge of `ext_trig`, otherwise the rising edge. The selected edge also sets the external pending flag (status bit 9).
- R12: In mode 2, each `scan_tick` pulse converts the next list entry.
- R13: `irq` equals control word 1 bit 15 AND the OR of pending bits [12:8] masked by control word 1 bits [12:8]. Any write to offset 0x4 clears all pending bits.
- R14: Status bit 8 is set when the result count reaches half. `ctr_a_evt` sets bit 11 and `ctr_b_evt` sets bit 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle; side effects take place at the clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| ext_trig | input | 1 | External trigger level |
| scan_tick | input | 1 | Scan trigger pulse |
| ctr_a_evt | input | 1 | Counter A event pulse |
| ctr_b_evt | input | 1 | Counter B event pulse |
| conv_start | output | 1 | One-cycle converter start |
| conv_done | input | 1 | Converter result valid, one cycle |
| conv_data | input | 12 | Converter result |
| fe_chan | output | 4 | Selected input channel |
| fe_gain | output | 2 | Gain code |
| fe_unipolar | output | 1 | Unipolar range select |
| fe_diff | output | 1 | Differential input select |
| irq | output | 1 | Interrupt request |

## Verification
A trigger accepted at clock edge N raises `conv_start` during the cycle after N. The front-end fields are valid in that same cycle. The bench's converter model returns `conv_done` three cycles later, and the result is poppable from the following cycle. The bench waits eight cycles after every trigger before it reads anything.

A monitor samples `conv_start` at the falling clock edge and compares the front-end fields against a queue of expected entries. Any start with no queued entry is reported, which is how ignored triggers are checked. Register results are sampled one nanosecond after the read strobe is set, before the clock edge that applies the pop. Pending and interrupt values are read one full cycle after the write that changes them.

// File: rtl/adc_list_seq.sv
module adc_list_seq #(
  parameter int DEPTH = 16,
  parameter int SW    = 12,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  input  logic          ext_trig,
  input  logic          scan_tick,
  input  logic          ctr_a_evt,
  input  logic          ctr_b_evt,
  output logic          conv_start,
  input  logic          conv_done,
  input  logic [SW-1:0] conv_data,
  output logic [3:0]    fe_chan,
  output logic [1:0]    fe_gain,
  output logic          fe_unipolar,
  output logic          fe_diff,
  output logic          irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);
  localparam logic [CW-1:0] HALFC = CW'(DEPTH / 2);
  localparam logic [AW-1:0] A_CTL1 = AW'(0);
  localparam logic [AW-1:0] A_CTL2 = AW'(2);
  localparam logic [AW-1:0] A_STAT = AW'(4);
  localparam logic [AW-1:0] A_LIST = AW'(16);

  logic [15:0]   ctl1;
  logic          res_en, list_en;
  logic [7:0]    lmem [DEPTH];
  logic [CW-1:0] lcnt, lptr;
  logic [SW-1:0] rmem [DEPTH];
  logic [PW-1:0] rwp, rrp;
  logic [CW-1:0] rcnt;
  logic [SW-1:0] rlast;
  logic          busy, start_q, ext_q;
  logic [4:0]    pend;

  wire [CW-1:0] lnext   = lptr + CW'(1);
  wire          lpush   = bus_wr && bus_addr == A_LIST && list_en && lcnt != FULLC;
  wire          pop     = bus_rd && bus_addr == A_LIST && rcnt != '0;
  wire          push    = busy && conv_done && res_en && rcnt != FULLC;
  wire          done    = busy && conv_done;
  wire          ext_hit = ctl1[3] ? (ext_q && !ext_trig) : (!ext_q && ext_trig);
  wire          half_hit = push && !pop && rcnt == HALFC - CW'(1);
  wire          list_end = done && lnext >= lcnt;
  wire [4:0]    pset    = {ctr_b_evt, ctr_a_evt, list_end, ext_hit, half_hit};
  wire [7:0]    entry   = lmem[lptr[PW-1:0]];

  logic trig;
  always_comb begin
    case (ctl1[1:0])
      2'd1:    trig = bus_rd && bus_addr == A_CTL1;
      2'd2:    trig = scan_tick;
      2'd3:    trig = ext_hit;
      default: trig = 1'b0;
    endcase
  end

  wire go = trig && !busy && lcnt != '0 && (lptr < lcnt || ctl1[2]);

  assign conv_start  = start_q;
  assign fe_chan     = entry[3:0];
  assign fe_gain     = entry[5:4];
  assign fe_unipolar = entry[6];
  assign fe_diff     = entry[7];
  assign irq         = ctl1[15] && |(pend & ctl1[12:8]);

  always_comb begin
    case (bus_addr)
      A_STAT:  bus_rdata = {3'b0, pend, 3'b0, rcnt == FULLC, rcnt >= HALFC,
                            rcnt == '0, lcnt == FULLC, busy};
      A_LIST:  bus_rdata = 16'(rcnt == '0 ? rlast : rmem[rrp]);
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (lpush) lmem[lcnt[PW-1:0]] <= bus_wdata[7:0];
    if (push)  rmem[rwp] <= conv_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl1 <= '0; res_en <= 1'b0; list_en <= 1'b0;
      ext_q <= 1'b0; pend <= '0;
    end else begin
      ext_q <= ext_trig;
      if (bus_wr && bus_addr == A_CTL1) ctl1 <= bus_wdata;
      if (bus_wr && bus_addr == A_CTL2) {res_en, list_en} <= bus_wdata[10:9];
      if (bus_wr && bus_addr == A_STAT) pend <= '0;
      else                              pend <= pend | pset;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcnt <= '0; lptr <= '0; busy <= 1'b0; start_q <= 1'b0;
    end else begin
      start_q <= go;
      if (lpush) lcnt <= lcnt + CW'(1);
      if (go) begin
        busy <= 1'b1;
        if (lptr >= lcnt) lptr <= '0;
      end else if (done) begin
        busy <= 1'b0;
        lptr <= (lnext >= lcnt && ctl1[2]) ? '0 : lnext;
      end
      if (!list_en) begin
        lcnt <= '0;
        lptr <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rwp <= '0; rrp <= '0; rcnt <= '0; rlast <= '0;
    end else if (!res_en) begin
      rwp <= '0; rrp <= '0; rcnt <= '0;
    end else begin
      if (push) rwp <= rwp + PW'(1);
      if (pop) begin
        rrp   <= rrp + PW'(1);
        rlast <= rmem[rrp];
      end
      rcnt <= rcnt + CW'(push) - CW'(pop);
    end
  end

  // R6
  res_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rcnt <= FULLC && lcnt <= FULLC);

  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R13
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_STAT) |=> (bus_rdata[12:8] == 5'd0 || bus_addr != A_STAT));

  // R9
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_done && list_en) |=> $stable(lptr));

  // R7
  list_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !list_en |=> lcnt == '0);
endmodule

// File: tb/tb_adc_list_seq.sv
module tb_adc_list_seq;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic        ext_trig = 1'b0, scan_tick = 1'b0, ctr_a_evt = 1'b0, ctr_b_evt = 1'b0;
  logic        conv_start, conv_done = 1'b0;
  logic [11:0] conv_data = '0;
  logic [3:0]  fe_chan;
  logic [1:0]  fe_gain;
  logic        fe_unipolar, fe_diff, irq;

  int checks = 0, errors = 0;
  logic [7:0]  exp_q [$];
  logic [11:0] samp_q [$];
  logic        drop = 1'b0;
  logic [7:0]  mon_n = '0, cv_n = '0;
  logic [11:0] last_s = '0;

  always #5 clk = ~clk;

  adc_list_seq dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_trig(ext_trig),
    .scan_tick(scan_tick), .ctr_a_evt(ctr_a_evt), .ctr_b_evt(ctr_b_evt),
    .conv_start(conv_start), .conv_done(conv_done), .conv_data(conv_data),
    .fe_chan(fe_chan), .fe_gain(fe_gain), .fe_unipolar(fe_unipolar),
    .fe_diff(fe_diff), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // converter model: result three cycles after start
  always begin
    @(negedge clk);
    if (conv_start) begin
      logic [3:0] c;
      c = fe_chan;
      repeat (3) @(negedge clk);
      conv_data = {c, cv_n};
      cv_n++;
      conv_done = 1'b1;
      @(negedge clk);
      conv_done = 1'b0;
    end
  end

  // monitor: every start must match the next expected entry (R2, R3)
  always @(negedge clk) begin
    if (conv_start) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected conversion actual=%0h expected=none",
                 {fe_diff, fe_unipolar, fe_gain, fe_chan});
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if ({fe_diff, fe_unipolar, fe_gain, fe_chan} !== e) begin
          errors++;
          $display("FAIL R3 front end actual=%0h expected=%0h",
                   {fe_diff, fe_unipolar, fe_gain, fe_chan}, e);
        end
        if (!drop) samp_q.push_back({e[3:0], mon_n});
      end
      mon_n++;
    end
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic fire(input logic [7:0] e);
    logic [15:0] d;
    exp_q.push_back(e);
    rd(5'h0, d);
    settle();
  endtask

  task automatic pop_chk(input string tag);
    logic [15:0] d;
    logic [11:0] e;
    rd(5'h10, d);
    e = samp_q.size() ? samp_q.pop_front() : 12'hfff;
    last_s = e;
    chk(tag, d, {4'h0, e});
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(5'h4, d);
    chk("R1 status", d, 16'h0004);
    chk("R1 irq", irq, 0);
    chk("R1 start", conv_start, 0);

    wr(5'h2, 16'h0600);
    wr(5'h10, 16'h00E3); wr(5'h10, 16'h0005); wr(5'h10, 16'h001A);
    rd(5'h0, d); settle();
    rd(5'h4, d);
    chk("R2 mode0 idle", d, 16'h0004);

    wr(5'h0, 16'h0001);
    fire(8'hE3); fire(8'h05); fire(8'h1A);
    rd(5'h0, d); settle();
    rd(5'h4, d);
    chk("R9 end of list", d, 16'h0400);
    pop_chk("R4 first"); pop_chk("R4 second"); pop_chk("R4 third");
    rd(5'h10, d);
    chk("R5 empty pop", d, {4'h0, last_s});
    rd(5'h4, d);
    chk("R5 still empty", d, 16'h0404);
    wr(5'h4, 16'h0000);
    rd(5'h4, d);
    chk("R13 clear", d, 16'h0004);

    wr(5'h2, 16'h0400); wr(5'h2, 16'h0600);
    wr(5'h10, 16'h0007); wr(5'h0, 16'h0005);
    for (int i = 0; i < 3; i++) fire(8'h07);
    for (int i = 0; i < 3; i++) pop_chk("R10 wrap");

    for (int i = 0; i < 17; i++) fire(8'h07);
    rd(5'h4, d);
    chk("R8 full half", d[4:0], 5'h18);
    chk("R14 half pend", d[8], 1);
    wr(5'h0, 16'h8105);
    @(negedge clk);
    chk("R13 irq on", irq, 1);
    wr(5'h0, 16'h0105);
    @(negedge clk);
    chk("R13 global off", irq, 0);
    wr(5'h0, 16'h8005);
    @(negedge clk);
    chk("R13 masked", irq, 0);
    for (int i = 0; i < 16; i++) pop_chk("R6 full fifo");
    void'(samp_q.pop_back());
    rd(5'h4, d);
    chk("R6 drop 17th", d[2], 1);
    wr(5'h4, 16'h0000);

    wr(5'h2, 16'h0400);
    wr(5'h10, 16'h0009);
    wr(5'h2, 16'h0600);
    wr(5'h0, 16'h0001);
    rd(5'h0, d); settle();
    rd(5'h4, d);
    chk("R7 list write lost", d, 16'h0004);
    wr(5'h2, 16'h0200);
    wr(5'h10, 16'h0009);
    drop = 1'b1; fire(8'h09); drop = 1'b0;
    wr(5'h2, 16'h0600);
    rd(5'h4, d);
    chk("R7 result lost", d[4:0], 5'h04);

    wr(5'h2, 16'h0400); wr(5'h2, 16'h0600);
    wr(5'h10, 16'h0009); wr(5'h0, 16'h0007); wr(5'h4, 16'h0000);
    exp_q.push_back(8'h09);
    @(negedge clk); ext_trig = 1'b1; settle();
    ext_trig = 1'b0; settle();
    rd(5'h4, d);
    chk("R11 ext pend", d[9], 1);
    wr(5'h0, 16'h000F);
    ext_trig = 1'b1; settle();
    exp_q.push_back(8'h09);
    ext_trig = 1'b0; settle();
    pop_chk("R11 rising"); pop_chk("R11 falling");

    wr(5'h0, 16'h0006);
    exp_q.push_back(8'h09);
    @(negedge clk); scan_tick = 1'b1; @(negedge clk); scan_tick = 1'b0;
    settle();
    pop_chk("R12 scan");

    wr(5'h4, 16'h0000);
    @(negedge clk); ctr_a_evt = 1'b1; @(negedge clk); ctr_a_evt = 1'b0;
    rd(5'h4, d);
    chk("R14 counter a", d[12:8], 5'h08);
    @(negedge clk); ctr_b_evt = 1'b1; @(negedge clk); ctr_b_evt = 1'b0;
    rd(5'h4, d);
    chk("R14 counter b", d[12:8], 5'h18);
    wr(5'h0, 16'h8806);
    @(negedge clk);
    chk("R13 counter irq", irq, 1);
    wr(5'h4, 16'h0000);
    @(negedge clk);
    chk("R13 irq cleared", irq, 0);

    wr(5'h2, 16'h0400); wr(5'h2, 16'h0600);
    for (int i = 0; i < 16; i++) wr(5'h10, 16'(8'(i * 37)));
    wr(5'h10, 16'h00FF);
    rd(5'h4, d);
    chk("R6 list full", d[1], 1);
    wr(5'h0, 16'h0001);
    drop = 1'b1;
    for (int i = 0; i < 16; i++) fire(8'(i * 37));
    rd(5'h0, d); settle();
    drop = 1'b0;
    chk("R3 all entries used", exp_q.size(), 0);
    report();
  end
endmodule